// File: doc/BRIEF.md
# Snapshot Integration Sequencer

This block drives the global pixel-array control lines of a snapshot-shutter image sensor. For each frame it issues a full pixel reset, which opens the integration window. Near the end of that window it can issue an optional partial (double-slope) reset that extends the dynamic range. When integration ends it runs the charge-transfer chain: a memory hold pulse, then a precharge pulse, then a sample pulse. It then announces with a one-cycle frame-ready event that the stored frame can be read row by row. All times are programmed in clock cycles. The integration, double-slope and memory-hold lengths are captured at the start of each frame, so changing them in the middle of a frame has no effect on that frame.

The sequencer runs in one of two modes. In sequential mode the next reset waits until row readout has finished, signalled by the readout-busy input going low. In parallel mode the next reset starts at once, so frame N integrates while frame N-1 is still being read. The next charge transfer is then held back until readout-busy is low, which protects the frame being read. A run input keeps frames going while it is high. When it is low at the end of a frame, the block stops and stays idle.

Top module: `snapshot_seq`

## Requirements
- R1: After reset and while idle, the active-high lines `pix_rst_o`, `pix_ds_rst_o` and `frame_rdy_o` are 0, and the active-low lines `mem_hl_no`, `prech_no` and `sample_no` are 1.
- R2: A frame starts with `pix_rst_o` high for RST_W cycles. Integration then lasts `int_cycles_i` cycles, where a value of 0 counts as 1. With readout idle, the first low cycle of `mem_hl_no` comes int+1 cycles after the first cycle in which `pix_rst_o` is low again.
- R3: The double-slope pulse `pix_ds_rst_o` rises in the integration cycle at which `ds` cycles of integration remain, with that cycle counted. With readout idle, it therefore rises ds+1 cycles before `mem_hl_no` falls. It stays high for min(DS_W, ds) cycles.
- R4: A double-slope time of 0 produces no pulse. A double-slope time equal to or greater than the effective integration time is clamped to that time minus one, so with an integration time of 1 there is no pulse.
- R5: `mem_hl_no` is low for `mem_cycles_i` cycles, clamped to the range MEM_MIN..MEM_MAX (1000..1640 by default, which is 5 to 8.2 µs at 200 MHz).
- R6: `prech_no` goes low in the cycle in which `mem_hl_no` returns high and stays low for PRE_W cycles. `sample_no` goes low GAP_W cycles after `prech_no` returns high and stays low for SMP_W cycles (401 by default, more than 2 µs). No two control pulses are ever active in the same cycle.
- R7: `frame_rdy_o` is high for exactly one cycle, in the first cycle after `sample_no` returns high.
- R8: In sequential mode (`par_mode_i`=0), the next frame's reset rises one cycle after the cycle in which `rd_busy_i` is first seen low after frame-ready.
- R9: In parallel mode (`par_mode_i`=1) with run high, the next frame's reset rises in the cycle right after frame-ready, even while `rd_busy_i` is high.
- R10: The memory hold pulse never starts while readout is busy. It starts one cycle after the cycle in which `rd_busy_i` is first seen low after integration has ended.
- R11: If `run_i` is low when a frame ends, no further reset is issued and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Keep issuing frames while high |
| par_mode_i | input | 1 | 1 = parallel (overlapped) mode, 0 = sequential mode |
| rd_busy_i | input | 1 | Row readout of the previous frame is in progress |
| int_cycles_i | input | CNT_W | Integration time in cycles |
| ds_cycles_i | input | CNT_W | Time from the double-slope pulse to the end of integration, in cycles; 0 disables the pulse |
| mem_cycles_i | input | CNT_W | Requested width of the memory hold pulse in cycles |
| pix_rst_o | output | 1 | Pixel reset, active high |
| pix_ds_rst_o | output | 1 | Double-slope partial reset, active high |
| mem_hl_no | output | 1 | Memory hold pulse, active low |
| prech_no | output | 1 | Precharge pulse, active low |
| sample_no | output | 1 | Sample pulse, active low |
| frame_rdy_o | output | 1 | One-cycle event: the frame is stored and ready for readout |

## Verification
The assertions check on every cycle that no two pulses overlap, that each finished memory-hold pulse lies within its clamp range, and that each finished sample pulse has its full width. They also check that frame-ready follows the end of the sample pulse by one cycle, that the memory pulse never starts while busy was high, and that the sequencer stays idle or waiting when it should. Only the bench scenarios can show the exact placement of the pulses relative to programmed values. That covers the integration length, where the double-slope pulse falls and how it is clamped, and how mode and readout-busy move the next reset. The bench computes these as cycle offsets between observed output edges.

// File: rtl/snap_seq_pkg.sv
package snap_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_INT, S_XWAIT, S_MEM, S_PRE, S_GAP, S_SMP, S_RDY, S_RDWAIT
  } phase_e;
endpackage

// File: rtl/snap_cfg_latch.sv
module snap_cfg_latch #(
  parameter int CNT_W   = 16,
  parameter int MEM_MIN = 1000,
  parameter int MEM_MAX = 1640
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] int_cycles_i,
  input  logic [CNT_W-1:0] ds_cycles_i,
  input  logic [CNT_W-1:0] mem_cycles_i,
  output logic [CNT_W-1:0] int_len_o,
  output logic [CNT_W-1:0] ds_eff_o,
  output logic [CNT_W-1:0] mem_len_o
);
  localparam logic [CNT_W-1:0] MinV = CNT_W'(MEM_MIN);
  localparam logic [CNT_W-1:0] MaxV = CNT_W'(MEM_MAX);
  localparam logic [CNT_W-1:0] One  = CNT_W'(1);

  logic [CNT_W-1:0] int_d, ds_d, mem_d;

  always_comb begin
    int_d = (int_cycles_i == '0) ? One : int_cycles_i;
    if (ds_cycles_i == '0)         ds_d = '0;
    else if (ds_cycles_i >= int_d) ds_d = int_d - One;
    else                           ds_d = ds_cycles_i;
    if (mem_cycles_i < MinV)       mem_d = MinV;
    else if (mem_cycles_i > MaxV)  mem_d = MaxV;
    else                           mem_d = mem_cycles_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_len_o <= One;
      ds_eff_o  <= '0;
      mem_len_o <= MinV;
    end else if (load_i) begin
      int_len_o <= int_d;
      ds_eff_o  <= ds_d;
      mem_len_o <= mem_d;
    end
  end

  // R4
  ds_below_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_eff_o < int_len_o);
  // R5
  mem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_len_o >= MinV) && (mem_len_o <= MaxV));
endmodule

// File: rtl/snap_phase_fsm.sv
module snap_phase_fsm
  import snap_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RST_W = 20,
  parameter int PRE_W = 100,
  parameter int GAP_W = 201,
  parameter int SMP_W = 401
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             par_mode_i,
  input  logic             rd_busy_i,
  input  logic [CNT_W-1:0] int_len_i,
  input  logic [CNT_W-1:0] mem_len_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] One  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RstV = CNT_W'(RST_W - 1);
  localparam logic [CNT_W-1:0] PreV = CNT_W'(PRE_W - 1);
  localparam logic [CNT_W-1:0] GapV = CNT_W'(GAP_W - 1);
  localparam logic [CNT_W-1:0] SmpV = CNT_W'(SMP_W - 1);

  phase_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? '0 : cnt_q - One;
    unique case (st_q)
      S_IDLE:   if (run_i) begin st_d = S_RST; cnt_d = RstV; end
      S_RST:    if (last) begin st_d = S_INT; cnt_d = int_len_i - One; end
      S_INT:    if (last) st_d = S_XWAIT;
      S_XWAIT:  if (!rd_busy_i) begin st_d = S_MEM; cnt_d = mem_len_i - One; end
      S_MEM:    if (last) begin st_d = S_PRE; cnt_d = PreV; end
      S_PRE:    if (last) begin st_d = S_GAP; cnt_d = GapV; end
      S_GAP:    if (last) begin st_d = S_SMP; cnt_d = SmpV; end
      S_SMP:    if (last) st_d = S_RDY;
      S_RDY: begin
        if (!par_mode_i)  st_d = S_RDWAIT;
        else if (run_i)   begin st_d = S_RST; cnt_d = RstV; end
        else              st_d = S_IDLE;
      end
      S_RDWAIT: if (!rd_busy_i) begin
        if (run_i) begin st_d = S_RST; cnt_d = RstV; end
        else       st_d = S_IDLE;
      end
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = st_q;
  assign cnt_o   = cnt_q;
  assign load_o  = (st_d == S_RST) && (st_q != S_RST);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !run_i) |=> (st_q == S_IDLE));
  // R8
  seq_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RDWAIT && rd_busy_i) |=> (st_q == S_RDWAIT));
  // R9
  par_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RDY && par_mode_i && run_i) |=> (st_q == S_RST));
endmodule

// File: rtl/snap_pulse_dec.sv
module snap_pulse_dec
  import snap_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DS_W    = 20,
  parameter int MEM_MIN = 1000,
  parameter int MEM_MAX = 1640,
  parameter int SMP_W   = 401
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ds_eff_i,
  output logic             pix_rst_o,
  output logic             pix_ds_rst_o,
  output logic             mem_hl_no,
  output logic             prech_no,
  output logic             sample_no,
  output logic             frame_rdy_o
);
  localparam int XW = CNT_W + 2;
  localparam logic [XW-1:0] DsV = XW'(DS_W);

  logic [XW-1:0] rem, dse;

  // remaining integration cycles, current one included
  assign rem = XW'(cnt_i) + XW'(1);
  assign dse = XW'(ds_eff_i);

  assign pix_rst_o    = (phase_i == S_RST);
  assign pix_ds_rst_o = (phase_i == S_INT) && (dse != '0) && (rem <= dse) && ((rem + DsV) > dse);
  assign mem_hl_no    = !(phase_i == S_MEM);
  assign prech_no     = !(phase_i == S_PRE);
  assign sample_no    = !(phase_i == S_SMP);
  assign frame_rdy_o  = (phase_i == S_RDY);

  // run-length counters for the width checks
  logic [CNT_W:0] mem_lo, smp_lo, ds_hi;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_lo <= '0;
      smp_lo <= '0;
      ds_hi  <= '0;
    end else begin
      mem_lo <= mem_hl_no    ? '0 : mem_lo + 1'b1;
      smp_lo <= sample_no    ? '0 : smp_lo + 1'b1;
      ds_hi  <= pix_ds_rst_o ? ds_hi + 1'b1 : '0;
    end
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pix_rst_o, pix_ds_rst_o, ~mem_hl_no, ~prech_no, ~sample_no}) <= 1);
  // R5
  mem_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_hl_no) |-> (mem_lo >= (CNT_W+1)'(MEM_MIN)) && (mem_lo <= (CNT_W+1)'(MEM_MAX)));
  // R6
  smp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_no) |-> (smp_lo == (CNT_W+1)'(SMP_W)));
  // R3
  ds_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_ds_rst_o) |-> (ds_hi <= (CNT_W+1)'(DS_W)));
  // R7
  rdy_after_smp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_no) |-> frame_rdy_o);
  // R7
  rdy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rdy_o |=> !frame_rdy_o);
endmodule

// File: rtl/snapshot_seq.sv
module snapshot_seq
  import snap_seq_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RST_W   = 20,
  parameter int DS_W    = 20,
  parameter int MEM_MIN = 1000,
  parameter int MEM_MAX = 1640,
  parameter int PRE_W   = 100,
  parameter int GAP_W   = 201,
  parameter int SMP_W   = 401
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             par_mode_i,
  input  logic             rd_busy_i,
  input  logic [CNT_W-1:0] int_cycles_i,
  input  logic [CNT_W-1:0] ds_cycles_i,
  input  logic [CNT_W-1:0] mem_cycles_i,
  output logic             pix_rst_o,
  output logic             pix_ds_rst_o,
  output logic             mem_hl_no,
  output logic             prech_no,
  output logic             sample_no,
  output logic             frame_rdy_o
);
  logic [CNT_W-1:0] int_len, ds_eff, mem_len, cnt;
  logic             load;
  phase_e           phase;

  snap_cfg_latch #(
    .CNT_W(CNT_W), .MEM_MIN(MEM_MIN), .MEM_MAX(MEM_MAX)
  ) i_cfg (
    .clk_i, .rst_ni, .load_i(load),
    .int_cycles_i, .ds_cycles_i, .mem_cycles_i,
    .int_len_o(int_len), .ds_eff_o(ds_eff), .mem_len_o(mem_len)
  );

  snap_phase_fsm #(
    .CNT_W(CNT_W), .RST_W(RST_W), .PRE_W(PRE_W), .GAP_W(GAP_W), .SMP_W(SMP_W)
  ) i_fsm (
    .clk_i, .rst_ni, .run_i, .par_mode_i, .rd_busy_i,
    .int_len_i(int_len), .mem_len_i(mem_len),
    .phase_o(phase), .cnt_o(cnt), .load_o(load)
  );

  snap_pulse_dec #(
    .CNT_W(CNT_W), .DS_W(DS_W), .MEM_MIN(MEM_MIN), .MEM_MAX(MEM_MAX), .SMP_W(SMP_W)
  ) i_dec (
    .clk_i, .rst_ni, .phase_i(phase), .cnt_i(cnt), .ds_eff_i(ds_eff),
    .pix_rst_o, .pix_ds_rst_o, .mem_hl_no, .prech_no, .sample_no, .frame_rdy_o
  );

  // R10
  xfer_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_hl_no) |-> $past(!rd_busy_i));
endmodule

// File: tb/test_snapshot_seq.sv
`timescale 1ns/1ps
module test_snapshot_seq;
  localparam int CNT_W = 16, RST_W = 20, DS_W = 20, MEM_MIN = 1000, MEM_MAX = 1640;
  localparam int PRE_W = 100, GAP_W = 201, SMP_W = 401;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, run = 1'b0, par = 1'b0, rd_busy = 1'b0;
  logic [CNT_W-1:0] int_c = '0, ds_c = '0, mem_c = '0;
  logic pix_rst, pix_ds, mem_hl_n, prech_n, sample_n, frame_rdy;

  snapshot_seq #(
    .CNT_W(CNT_W), .RST_W(RST_W), .DS_W(DS_W), .MEM_MIN(MEM_MIN), .MEM_MAX(MEM_MAX),
    .PRE_W(PRE_W), .GAP_W(GAP_W), .SMP_W(SMP_W)
  ) i_snapshot_seq (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .par_mode_i(par), .rd_busy_i(rd_busy),
    .int_cycles_i(int_c), .ds_cycles_i(ds_c), .mem_cycles_i(mem_c),
    .pix_rst_o(pix_rst), .pix_ds_rst_o(pix_ds), .mem_hl_no(mem_hl_n),
    .prech_no(prech_n), .sample_no(sample_n), .frame_rdy_o(frame_rdy)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int t_rst_rise, t_rst_fall, t_ds_rise, t_ds_fall, t_mem_fall, t_mem_rise;
  int t_pre_fall, t_pre_rise, t_smp_fall, t_smp_rise, t_fr, t_fr_fall, t_busy_fall;
  int n_rst = 0, n_ds = 0, n_fr = 0;
  int rd_len = 0, rd_left = 0;
  logic p_rst = 0, p_ds = 0, p_mem = 1, p_pre = 1, p_smp = 1, p_fr = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge monitor and readout model, at the inactive edge
  always @(negedge clk) begin
    cyc++;
    if (pix_rst && !p_rst) begin t_rst_rise = cyc; n_rst++; end
    if (!pix_rst && p_rst) t_rst_fall = cyc;
    if (pix_ds && !p_ds) begin t_ds_rise = cyc; n_ds++; end
    if (!pix_ds && p_ds) t_ds_fall = cyc;
    if (!mem_hl_n && p_mem) t_mem_fall = cyc;
    if (mem_hl_n && !p_mem) t_mem_rise = cyc;
    if (!prech_n && p_pre) t_pre_fall = cyc;
    if (prech_n && !p_pre) t_pre_rise = cyc;
    if (!sample_n && p_smp) t_smp_fall = cyc;
    if (sample_n && !p_smp) t_smp_rise = cyc;
    if (frame_rdy && !p_fr) begin t_fr = cyc; n_fr++; end
    if (!frame_rdy && p_fr) t_fr_fall = cyc;
    if (frame_rdy && rd_len > 0) begin
      rd_busy = 1'b1; rd_left = rd_len;
    end else if (rd_busy) begin
      rd_left--;
      if (rd_left == 0) begin rd_busy = 1'b0; t_busy_fall = cyc; end
    end
    p_rst = pix_rst; p_ds = pix_ds; p_mem = mem_hl_n;
    p_pre = prech_n; p_smp = sample_n; p_fr = frame_rdy;
  end

  task automatic wait_cnt(ref int ctr, input int target);
    while (ctr < target) @(posedge clk);
  endtask

  task automatic set_cfg(int it, int ds, int mem);
    @(negedge clk);
    int_c = CNT_W'(it); ds_c = CNT_W'(ds); mem_c = CNT_W'(mem);
  endtask

  // checks of the per-frame pulse train; busy assumed low at integration end
  task automatic check_frame(int il, int de, int ml, int ds_base);
    chk("R2", "reset width", t_rst_fall - t_rst_rise, RST_W);
    chk("R2", "integration to memory pulse", t_mem_fall - t_rst_fall, il + 1);
    if (de > 0) begin
      chk("R3", "ds rise to memory pulse", t_mem_fall - t_ds_rise, de + 1);
      chk("R3", "ds width", t_ds_fall - t_ds_rise, (de < DS_W) ? de : DS_W);
    end else begin
      chk("R4", "ds pulse count", n_ds - ds_base, 0);
    end
    chk("R5", "memory width", t_mem_rise - t_mem_fall, ml);
    chk("R6", "precharge start", t_pre_fall, t_mem_rise);
    chk("R6", "precharge width", t_pre_rise - t_pre_fall, PRE_W);
    chk("R6", "precharge to sample", t_smp_fall - t_pre_rise, GAP_W);
    chk("R6", "sample width", t_smp_rise - t_smp_fall, SMP_W);
    chk("R7", "frame ready position", t_fr, t_smp_rise);
    chk("R7", "frame ready width", t_fr_fall - t_fr, 1);
  endtask

  task automatic one_frame(int it, int ds, int mem, int il, int de, int ml);
    int rb, fb, db;
    rb = n_rst; fb = n_fr; db = n_ds;
    set_cfg(it, ds, mem);
    run = 1'b1;
    wait_cnt(n_rst, rb + 1);
    @(negedge clk) run = 1'b0;
    wait_cnt(n_fr, fb + 1);
    repeat (3) @(posedge clk);
    check_frame(il, de, ml, db);
    repeat (50) @(posedge clk);
    chk("R11", "no restart with run low", n_rst, rb + 1);
  endtask

  task automatic test_reset_state;
    chk("R1", "pix_rst idle", int'(pix_rst), 0);
    chk("R1", "ds idle", int'(pix_ds), 0);
    chk("R1", "mem_hl_n idle", int'(mem_hl_n), 1);
    chk("R1", "prech_n idle", int'(prech_n), 1);
    chk("R1", "sample_n idle", int'(sample_n), 1);
    chk("R1", "frame_rdy idle", int'(frame_rdy), 0);
  endtask

  task automatic test_nominal;
    one_frame(500, 40, 1200, 500, 40, 1200);
  endtask

  task automatic test_mem_clamp;
    one_frame(300, 0, 10, 300, 0, MEM_MIN);      // R5 low clamp, R4 ds off
    one_frame(300, 25, 5000, 300, 25, MEM_MAX);  // R5 high clamp
  endtask

  task automatic test_ds_edges;
    one_frame(30, 100, 1100, 30, 29, 1100);      // R4 ds clamp to int-1
    one_frame(0, 5, 1000, 1, 0, 1000);           // R2 zero int, R4 no ds
    one_frame(400, 7, 1000, 400, 7, 1000);       // R3 short ds pulse
  endtask

  task automatic test_seq_busy;
    int rb, fb, tf;
    rb = n_rst; fb = n_fr;
    set_cfg(100, 0, 1000);
    rd_len = 300; par = 1'b0; run = 1'b1;
    wait_cnt(n_fr, fb + 1);
    tf = t_fr;
    wait_cnt(n_rst, rb + 2);
    chk("R8", "sequential restart after busy", t_rst_rise, tf + 300 + 1);
    @(negedge clk) run = 1'b0;
    wait_cnt(n_fr, fb + 2);
    while (rd_busy) @(posedge clk);
    repeat (5) @(posedge clk);
    chk("R11", "stopped after sequential run", n_rst, rb + 2);
    rd_len = 0;
  endtask

  task automatic test_par_busy;
    int rb, fb, tf;
    rb = n_rst; fb = n_fr;
    set_cfg(200, 20, 1000);
    rd_len = 3000; par = 1'b1; run = 1'b1;
    wait_cnt(n_fr, fb + 1);
    tf = t_fr;
    wait_cnt(n_rst, rb + 2);
    chk("R9", "parallel restart", t_rst_rise, tf + 1);
    chk("R9", "busy during next reset", int'(rd_busy), 1);
    @(negedge clk) run = 1'b0;
    wait_cnt(n_fr, fb + 2);
    repeat (3) @(posedge clk);
    chk("R10", "transfer waits for busy", t_mem_fall, tf + 3000 + 1);
    chk("R5", "memory width parallel", t_mem_rise - t_mem_fall, 1000);
    chk("R3", "ds width parallel", t_ds_fall - t_ds_rise, 20);
    while (rd_busy) @(posedge clk);
    repeat (5) @(posedge clk);
    chk("R11", "stopped after parallel run", n_rst, rb + 2);
    rd_len = 0; par = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    test_reset_state();
    test_nominal();
    test_mem_clamp();
    test_ds_edges();
    test_seq_busy();
    test_par_busy();
    test_reset_state();
    finish_run();
  end
endmodule